// File: doc/BRIEF.md
# MOESI Line Coherence State Controller

This block keeps the coherence state of every line held in one private cache, using five states: Modified, Owned, Exclusive, Shared and Invalid. Each cycle it can take one request from the local processor and one observed request from another cache. A flag tells it whether some other cache also holds the line being requested. From the stored state it works out the new state, and it decides which bus or directory action the cache must take: fetch for reading, fetch for ownership, invalidate other copies, supply data to a snooper, or write dirty data back to memory. Data, tags and the interconnect are outside this block.

Exclusive marks a line that no other cache holds and that memory also holds up to date, so a local write moves it to Modified without any bus traffic. Owned marks a line that holds the newest value while memory may be stale. Other caches may hold that line Shared. An Owned line serves readers directly instead of writing back first.

The action strobes are combinational and belong to the cycle in which the request is presented. The new state is registered at the next rising clock edge. A query port reads the stored state of any line.

Top module: `moesi_line_ctrl`

## Requirements
- R1: After reset every line reads Invalid on the query port. State codes are Invalid=0, Shared=1, Exclusive=2, Owned=3, Modified=4.
- R2: A local read (locOp=0) on an Invalid line raises busRead. The line becomes Exclusive when sharedIn is 0 and Shared when sharedIn is 1. A local read on any other state raises no strobe and leaves the state unchanged.
- R3: A local write (locOp=1) always leaves the line Modified. From Invalid it raises busRfo. From Shared or Owned it raises busInv. From Exclusive or Modified it raises no strobe.
- R4: An eviction (locOp=2) leaves the line Invalid. It raises writeBack from Modified or Owned, and raises no strobe from Exclusive, Shared or Invalid.
- R5: A clean request (locOp=3) on an Owned line raises writeBack and moves the line to Shared. On a Modified line it raises writeBack and moves the line to Exclusive. On any other state it raises no strobe and leaves the state unchanged.
- R6: A snooped read (snpOp=0) moves Modified to Owned and raises supplyData. On Owned it raises supplyData and keeps Owned. It moves Exclusive to Shared without supplyData. Shared and Invalid are left unchanged, with no strobe.
- R7: A snooped invalidate (snpOp=1) sends every state to Invalid. It raises supplyData only when the line was Modified or Owned.
- R8: When the local request and the snoop target the same line in one cycle, the snoop is applied first. The local request is then judged on the state the snoop leaves. The strobes of both parts appear together, and only the combined final state is stored.
- R9: A local request and a snoop on different lines in the same cycle are handled independently, and both lines are updated.
- R10: The strobes are valid in the cycle of the request, and at most one of busRead, busRfo and busInv is high. State changes become visible on qryState after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| locValid | input | 1 | Local request present |
| locOp | input | 2 | Local operation: 0 read, 1 write, 2 evict, 3 clean |
| locIdx | input | IDX_W | Line addressed by the local request |
| snpValid | input | 1 | Snooped request present |
| snpOp | input | 1 | Snooped operation: 0 read, 1 invalidate |
| snpIdx | input | IDX_W | Line addressed by the snoop |
| sharedIn | input | 1 | Another cache holds the locally requested line |
| qryIdx | input | IDX_W | Line selected for the query port |
| qryState | output | 3 | Stored state of the queried line |
| busRead | output | 1 | Issue a read fetch |
| busRfo | output | 1 | Issue a read-for-ownership |
| busInv | output | 1 | Invalidate other copies |
| supplyData | output | 1 | Drive line data to the snooping requester |
| writeBack | output | 1 | Write line data back to memory |

## Verification
The case that needs care is a local request and a snoop on the same line in one cycle. There the local decision must be based on the state the snoop leaves, not on the stored state. Directed cases set up this collision:
- a snooped read and a local write hitting a Modified line together, which must give supplyData, busInv and Modified;
- a snooped invalidate and a local read hitting a Modified line together, which must give supplyData, busRead and a fresh Exclusive or Shared state.

Random traffic over a small index range then makes collisions frequent. Every cycle the strobes are compared with a reference model that applies the snoop and then the local request. Every line is also read back through the query port.

// File: rtl/moesi_pkg.sv
package moesi_pkg;

  typedef enum logic [2:0] {
    ST_I = 3'd0,
    ST_S = 3'd1,
    ST_E = 3'd2,
    ST_O = 3'd3,
    ST_M = 3'd4
  } lineState_t;

  typedef enum logic [1:0] {
    LOC_RD    = 2'd0,
    LOC_WR    = 2'd1,
    LOC_EVICT = 2'd2,
    LOC_CLEAN = 2'd3
  } locOp_t;

  typedef enum logic {
    SNP_RD  = 1'b0,
    SNP_INV = 1'b1
  } snpOp_t;

  // Strobes from control to the state array
  typedef struct packed {
    logic       locWr;
    logic       snpWr;
    lineState_t locNext;
    lineState_t snpNext;
  } stateStrobe_t;

  // Bus and directory actions
  typedef struct packed {
    logic busRead;
    logic busRfo;
    logic busInv;
    logic supply;
    logic writeBack;
  } busAct_t;

endpackage

// File: rtl/moesi_ctrl.sv
module moesi_ctrl
  import moesi_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             locValid,
  input  locOp_t           locOp,
  input  logic [IDX_W-1:0] locIdx,
  input  logic             snpValid,
  input  snpOp_t           snpOp,
  input  logic [IDX_W-1:0] snpIdx,
  input  logic             sharedIn,
  input  lineState_t       locCur,
  input  lineState_t       snpCur,
  output stateStrobe_t     strobe,
  output busAct_t          act
);

  logic       sameLine;
  lineState_t snpNxt;
  logic       snpSupply;
  lineState_t locBase;
  lineState_t locNxt;
  logic       doRead, doRfo, doInv, doWb;

  assign sameLine = locValid && snpValid && (locIdx == snpIdx);

  // Snoop side: reacts to another cache's request
  always_comb begin
    snpNxt    = snpCur;
    snpSupply = 1'b0;
    if (snpOp == SNP_INV) begin
      snpNxt    = ST_I;
      snpSupply = (snpCur == ST_M) || (snpCur == ST_O);
    end else begin
      unique case (snpCur)
        ST_M: begin snpNxt = ST_O; snpSupply = 1'b1; end
        ST_O: begin snpNxt = ST_O; snpSupply = 1'b1; end
        ST_E: snpNxt = ST_S;
        default: snpNxt = snpCur;
      endcase
    end
  end

  // On a collision the local request sees the post-snoop state
  assign locBase = sameLine ? snpNxt : locCur;

  always_comb begin
    locNxt = locBase;
    doRead = 1'b0;
    doRfo  = 1'b0;
    doInv  = 1'b0;
    doWb   = 1'b0;
    unique case (locOp)
      LOC_RD: begin
        if (locBase == ST_I) begin
          doRead = 1'b1;
          locNxt = sharedIn ? ST_S : ST_E;
        end
      end
      LOC_WR: begin
        locNxt = ST_M;
        doRfo  = (locBase == ST_I);
        doInv  = (locBase == ST_S) || (locBase == ST_O);
      end
      LOC_EVICT: begin
        locNxt = ST_I;
        doWb   = (locBase == ST_M) || (locBase == ST_O);
      end
      LOC_CLEAN: begin
        if (locBase == ST_O) begin
          locNxt = ST_S;
          doWb   = 1'b1;
        end else if (locBase == ST_M) begin
          locNxt = ST_E;
          doWb   = 1'b1;
        end
      end
      default: locNxt = locBase;
    endcase
  end

  always_comb begin
    strobe.locWr   = locValid;
    strobe.snpWr   = snpValid && !sameLine;
    strobe.locNext = locNxt;
    strobe.snpNext = snpNxt;
    act.busRead    = locValid && doRead;
    act.busRfo     = locValid && doRfo;
    act.busInv     = locValid && doInv;
    act.writeBack  = locValid && doWb;
    act.supply     = snpValid && snpSupply;
  end

endmodule

// File: rtl/moesi_lines.sv
module moesi_lines
  import moesi_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int IDX_W     = 3
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  stateStrobe_t                  strobe,
  input  logic [IDX_W-1:0]              locIdx,
  input  logic [IDX_W-1:0]              snpIdx,
  input  logic [IDX_W-1:0]              qryIdx,
  output lineState_t                    locCur,
  output lineState_t                    snpCur,
  output lineState_t                    qryCur,
  output logic [NUM_LINES-1:0][2:0]     stateVec
);

  localparam logic [IDX_W:0] LINE_LIMIT = (IDX_W+1)'(NUM_LINES);

  lineState_t lineSt [NUM_LINES];

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
    always_ff @(posedge clk) begin
      if (!rstN) begin
        lineSt[i] <= ST_I;
      end else if (strobe.locWr && (locIdx == MY_IDX)) begin
        lineSt[i] <= strobe.locNext;
      end else if (strobe.snpWr && (snpIdx == MY_IDX)) begin
        lineSt[i] <= strobe.snpNext;
      end
    end
    assign stateVec[i] = lineSt[i];
  end

  assign locCur = ({1'b0, locIdx} < LINE_LIMIT) ? lineSt[locIdx] : ST_I;
  assign snpCur = ({1'b0, snpIdx} < LINE_LIMIT) ? lineSt[snpIdx] : ST_I;
  assign qryCur = ({1'b0, qryIdx} < LINE_LIMIT) ? lineSt[qryIdx] : ST_I;

endmodule

// File: rtl/moesi_line_ctrl.sv
module moesi_line_ctrl
  import moesi_pkg::*;
#(
  parameter  int NUM_LINES = 8,
  localparam int IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             locValid,
  input  logic [1:0]       locOp,
  input  logic [IDX_W-1:0] locIdx,
  input  logic             snpValid,
  input  logic             snpOp,
  input  logic [IDX_W-1:0] snpIdx,
  input  logic             sharedIn,
  input  logic [IDX_W-1:0] qryIdx,
  output logic [2:0]       qryState,
  output logic             busRead,
  output logic             busRfo,
  output logic             busInv,
  output logic             supplyData,
  output logic             writeBack
);

  stateStrobe_t              strobe;
  busAct_t                   act;
  lineState_t                locCur, snpCur, qryCur;
  logic [NUM_LINES-1:0][2:0] stateVec;

  moesi_ctrl #(.IDX_W(IDX_W)) ctrl_i (
    .locValid (locValid),
    .locOp    (locOp_t'(locOp)),
    .locIdx   (locIdx),
    .snpValid (snpValid),
    .snpOp    (snpOp_t'(snpOp)),
    .snpIdx   (snpIdx),
    .sharedIn (sharedIn),
    .locCur   (locCur),
    .snpCur   (snpCur),
    .strobe   (strobe),
    .act      (act)
  );

  moesi_lines #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) lines_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .locIdx   (locIdx),
    .snpIdx   (snpIdx),
    .qryIdx   (qryIdx),
    .locCur   (locCur),
    .snpCur   (snpCur),
    .qryCur   (qryCur),
    .stateVec (stateVec)
  );

  assign qryState   = qryCur;
  assign busRead    = act.busRead;
  assign busRfo     = act.busRfo;
  assign busInv     = act.busInv;
  assign supplyData = act.supply;
  assign writeBack  = act.writeBack;

endmodule

// File: rtl/moesi_line_chk.sv
module moesi_line_chk #(
  parameter int NUM_LINES = 8,
  parameter int IDX_W     = 3
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      locValid,
  input logic [1:0]                locOp,
  input logic [IDX_W-1:0]          locIdx,
  input logic                      snpValid,
  input logic                      snpOp,
  input logic [IDX_W-1:0]          snpIdx,
  input logic                      busRead,
  input logic                      busRfo,
  input logic                      busInv,
  input logic                      supplyData,
  input logic                      writeBack,
  input logic [NUM_LINES-1:0][2:0] stateVec
);

  logic collide;
  assign collide = locValid && snpValid && (locIdx == snpIdx);

  p_one_req_r10: assert property (@(posedge clk) disable iff (!rstN)
    $countones({busRead, busRfo, busInv}) <= 1);

  p_write_gives_m_r3: assert property (@(posedge clk) disable iff (!rstN)
    (locValid && locOp == 2'd1) |=> stateVec[$past(locIdx)] == 3'd4);

  p_silent_e_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    (locValid && locOp == 2'd1 && !collide && stateVec[locIdx] == 3'd2)
      |-> (!busRfo && !busInv));

  p_evict_to_i_r4: assert property (@(posedge clk) disable iff (!rstN)
    (locValid && locOp == 2'd2) |=> stateVec[$past(locIdx)] == 3'd0);

  p_wb_cause_r5: assert property (@(posedge clk) disable iff (!rstN)
    writeBack |-> (locValid && locOp[1]));

  p_supply_cause_r6: assert property (@(posedge clk) disable iff (!rstN)
    supplyData |-> snpValid);

  p_inv_to_i_r7: assert property (@(posedge clk) disable iff (!rstN)
    (snpValid && snpOp && !collide) |=> stateVec[$past(snpIdx)] == 3'd0);

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_legal
    p_legal_code_r1: assert property (@(posedge clk) disable iff (!rstN)
      stateVec[i] <= 3'd4);
  end

endmodule

bind moesi_line_ctrl moesi_line_chk #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .locValid   (locValid),
  .locOp      (locOp),
  .locIdx     (locIdx),
  .snpValid   (snpValid),
  .snpOp      (snpOp),
  .snpIdx     (snpIdx),
  .busRead    (busRead),
  .busRfo     (busRfo),
  .busInv     (busInv),
  .supplyData (supplyData),
  .writeBack  (writeBack),
  .stateVec   (stateVec)
);

// File: tb/moesi_line_ctrl_tb_top.sv
`timescale 1ns/1ps
module moesi_line_ctrl_tb_top;

  localparam int LINES = 8;
  localparam int IW    = 3;
  localparam logic [2:0] CI = 3'd0, CS = 3'd1, CE = 3'd2, CO = 3'd3, CM = 3'd4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          locValid = 1'b0;
  logic [1:0]    locOp = 2'd0;
  logic [IW-1:0] locIdx = '0;
  logic          snpValid = 1'b0;
  logic          snpOp = 1'b0;
  logic [IW-1:0] snpIdx = '0;
  logic          sharedIn = 1'b0;
  logic [IW-1:0] qryIdx = '0;
  logic [2:0]    qryState;
  logic          busRead, busRfo, busInv, supplyData, writeBack;

  int checks = 0;
  int errors = 0;
  logic [2:0] expSt [LINES];

  always #2.5 clk = ~clk;

  moesi_line_ctrl #(.NUM_LINES(LINES)) dut_i (
    .clk(clk), .rstN(rstN), .locValid(locValid), .locOp(locOp), .locIdx(locIdx),
    .snpValid(snpValid), .snpOp(snpOp), .snpIdx(snpIdx), .sharedIn(sharedIn),
    .qryIdx(qryIdx), .qryState(qryState), .busRead(busRead), .busRfo(busRfo),
    .busInv(busInv), .supplyData(supplyData), .writeBack(writeBack)
  );

  function automatic void snpModel(input logic [2:0] s, input logic op,
                                   output logic [2:0] n, output logic sup);
    n = s; sup = 1'b0;
    if (op) begin
      n = CI; sup = (s == CM) || (s == CO);
    end else if (s == CM) begin
      n = CO; sup = 1'b1;
    end else if (s == CO) begin
      sup = 1'b1;
    end else if (s == CE) begin
      n = CS;
    end
  endfunction

  // returns {busRead, busRfo, busInv, writeBack}
  function automatic logic [3:0] locModel(input logic [2:0] s, input logic [1:0] op,
                                          input logic sh, output logic [2:0] n);
    logic [3:0] a = 4'b0000;
    n = s;
    case (op)
      2'd0: if (s == CI) begin a = 4'b1000; n = sh ? CS : CE; end
      2'd1: begin
        n = CM;
        if (s == CI) a = 4'b0100;
        else if (s == CS || s == CO) a = 4'b0010;
      end
      2'd2: begin n = CI; if (s == CM || s == CO) a = 4'b0001; end
      default: begin
        if (s == CO) begin n = CS; a = 4'b0001; end
        else if (s == CM) begin n = CE; a = 4'b0001; end
      end
    endcase
    return a;
  endfunction

  task automatic report(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkStates(input string tag);
    for (int i = 0; i < LINES; i++) begin
      qryIdx = IW'(i);
      #0.1;
      report({tag, " state"}, int'(qryState), int'(expSt[i]));
    end
  endtask

  task automatic doCycle(input string tag, input logic lv, input logic [1:0] lop,
                         input int li, input logic sv, input logic sop, input int si,
                         input logic sh);
    logic [2:0] sn, base, ln;
    logic sup, same;
    logic [3:0] la;
    @(negedge clk);
    checkStates(tag);
    locValid = lv; locOp = lop; locIdx = IW'(li);
    snpValid = sv; snpOp = sop; snpIdx = IW'(si); sharedIn = sh;
    #0.5;
    same = lv && sv && (li == si);
    snpModel(expSt[si], sop, sn, sup);
    base = same ? sn : expSt[li];
    la = locModel(base, lop, sh, ln);
    report({tag, " strobes"}, int'({busRead, busRfo, busInv, writeBack, supplyData}),
           int'({la & {4{lv}}, sup & sv}));
    @(posedge clk);
    if (sv && !same) expSt[si] = sn;
    if (lv) expSt[li] = ln;
    #0.1;
    locValid = 1'b0; snpValid = 1'b0;
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < LINES; i++) expSt[i] = CI;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    checkStates("R1 reset");
    // R2: read miss to Exclusive, then silent hit
    doCycle("R2 miss excl", 1, 2'd0, 0, 0, 0, 0, 0);
    doCycle("R2 hit", 1, 2'd0, 0, 0, 0, 0, 1);
    // R3: silent upgrade from Exclusive
    doCycle("R3 E write", 1, 2'd1, 0, 0, 0, 0, 0);
    // R6: snooped read on Modified
    doCycle("R6 M to O", 0, 2'd0, 0, 1, 0, 0, 0);
    doCycle("R6 O stays", 0, 2'd0, 0, 1, 0, 0, 0);
    // R3: write from Owned needs invalidate
    doCycle("R3 O write", 1, 2'd1, 0, 0, 0, 0, 0);
    doCycle("R6 M to O again", 0, 2'd0, 0, 1, 0, 0, 0);
    // R5: clean Owned to Shared
    doCycle("R5 O clean", 1, 2'd3, 0, 0, 0, 0, 0);
    doCycle("R5 S clean", 1, 2'd3, 0, 0, 0, 0, 0);
    // R2 shared miss, R3 write from Shared
    doCycle("R2 miss shared", 1, 2'd0, 1, 0, 0, 0, 1);
    doCycle("R3 S write", 1, 2'd1, 1, 0, 0, 0, 0);
    doCycle("R5 M clean", 1, 2'd3, 1, 0, 0, 0, 0);
    doCycle("R6 E snoop", 0, 2'd0, 0, 1, 0, 1, 0);
    doCycle("R4 S evict", 1, 2'd2, 1, 0, 0, 0, 0);
    doCycle("R3 I write", 1, 2'd1, 2, 0, 0, 0, 0);
    doCycle("R4 M evict", 1, 2'd2, 2, 0, 0, 0, 0);
    doCycle("R4 I evict", 1, 2'd2, 2, 0, 0, 0, 0);
    // R7: invalidates
    doCycle("R3 setup", 1, 2'd1, 3, 0, 0, 0, 0);
    doCycle("R7 M inv", 0, 2'd0, 0, 1, 1, 3, 0);
    doCycle("R7 S inv", 0, 2'd0, 0, 1, 1, 0, 0);
    // R8: same-line collisions
    doCycle("R8 setup", 1, 2'd1, 4, 0, 0, 0, 0);
    doCycle("R8 snprd+wr", 1, 2'd1, 4, 1, 0, 4, 0);
    doCycle("R8 inv+rd", 1, 2'd0, 4, 1, 1, 4, 1);
    doCycle("R8 setup2", 1, 2'd1, 5, 0, 0, 0, 0);
    doCycle("R8 inv+evict", 1, 2'd2, 5, 1, 1, 5, 0);
    // R9: different lines together
    doCycle("R9 setup", 1, 2'd1, 6, 0, 0, 0, 0);
    doCycle("R9 split", 1, 2'd0, 7, 1, 0, 6, 0);
    // R10 random traffic, small index range to force collisions
    for (int k = 0; k < 3000; k++) begin
      doCycle("R10 random", 1'($urandom % 4 != 0), 2'($urandom), int'($urandom % 4),
              1'($urandom % 2), 1'($urandom), int'($urandom % 4), 1'($urandom));
    end
    @(negedge clk);
    checkStates("R10 final");
    finishRun();
  end

endmodule